// File: doc/BRIEF.md
# Six-Requester Bus Arbiter with Selectable Priority Tables

This block decides which of six bus requesters owns a shared system bus. It issues one registered, one-hot grant at a time and picks the winner from one of four fixed priority tables. A two-bit field in a 32-bit control word chooses the table. An optional boost rule lifts the processor core to the top of the order whenever one of the other five requesters was the most recent one served. Separate enable bits let a pending IRQ or FIQ line take the bus away from the DMA engine, the USB host or the Ethernet MAC. While that line stays active, the arbiter also ignores new requests from that master.

Each requester drives a level request and holds it for as long as it needs the bus. The arbiter keeps a grant until its owner drops the request or the owner is revoked by an enabled interrupt. Only then does it arbitrate again. Software sets up the control word through a write strobe with write data. The word can be read back at any time on a read-data port.

Top module: `prio_bus_arbiter`

## Requirements
- R1: After synchronous reset, the grant vector is all zeros and the control word reads back as 0. This selects table 0 with boost and all interrupt enables off.
- R2: Requester bit positions in `req_i`/`gnt_o` are: 0 core, 1 raster, 2 cursor, 3 MAC, 4 USB, 5 DMA. Control word bits are: [1:0] table select, [3] core boost, [4] DMA-on-IRQ, [5] DMA-on-FIQ, [6] USB-on-IRQ, [7] USB-on-FIQ, [8] MAC-on-IRQ, [9] MAC-on-FIQ. Bits 2 and 31:10 read as zero.
- R3: `gnt_o` has at most one bit set. A set bit belongs to a requester whose request was high at the preceding clock edge.
- R4: While the current owner keeps requesting and is not revoked, the grant does not change, whatever other requests do.
- R5: Table 0, from highest to lowest priority: cursor, MAC, USB, DMA, core, raster.
- R6: Table 1, from highest to lowest priority: raster, cursor, MAC, USB, core, DMA.
- R7: Table 2, from highest to lowest priority: raster, cursor, DMA, USB, MAC, core.
- R8: Table 3, from highest to lowest priority: raster, DMA, MAC, USB, cursor, core.
- R9: With boost set, a requesting core wins the next arbitration if the latest grant went to any non-core requester. After a grant to the core, the core competes at its table position until some non-core requester is granted again. The boost history is cleared by reset.
- R10: With DMA-on-IRQ set and `irq_i` high, DMA loses its grant and receives none. Its requests are served again once `irq_i` falls.
- R11: The FIQ enables and the USB/MAC enables apply the same revoke-and-ignore rule to their own master and line only. A line whose enable bit is clear has no effect.
- R12: A revocation takes effect at the clock edge that samples the interrupt high. At that same edge the grant passes to the highest-priority remaining eligible requester, or to none if there is no such requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 6 | Bus requests, one bit per requester |
| irq_i | input | 1 | Normal interrupt line, active high |
| fiq_i | input | 1 | Fast interrupt line, active high |
| cfg_wr_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 32 | Control word write data |
| cfg_rdata_o | output | 32 | Control word read-back |
| gnt_o | output | 6 | Registered one-hot grant |

## Verification
The embedded assertions check, on every cycle:
- the grant is one-hot or empty and goes only to a requester;
- the grant holds while the owner still requests and is eligible;
- a master blocked by an interrupt is never granted on the following edge;
- reserved control bits read as zero.

The bench scenarios have to show the parts that depend on history or on tables:
- the exact winner under each of the four tables;
- the boost rule, which turns on and off with past grants;
- same-edge handover when a grant is revoked;
- the fact that interrupts with cleared enables, or aimed at other masters, change nothing.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NUM_M  = 6;
  localparam int IDX_W  = $clog2(NUM_M);
  localparam int REG_W  = 32;
  localparam int CTRL_W = 10;

  typedef enum logic [IDX_W-1:0] {
    M_CORE   = 3'd0,
    M_RASTER = 3'd1,
    M_CURSOR = 3'd2,
    M_MAC    = 3'd3,
    M_USB    = 3'd4,
    M_DMA    = 3'd5
  } master_e;

  typedef struct packed {
    logic       mac_fiq;
    logic       mac_irq;
    logic       usb_fiq;
    logic       usb_irq;
    logic       dma_fiq;
    logic       dma_irq;
    logic       boost;
    logic [1:0] order;
  } ctrl_t;

  // Requester that sits at position 'rank' (0 = highest) of table 'order'.
  function automatic master_e rank_master(input logic [1:0] order, input int rank);
    master_e m;
    m = M_CORE;
    unique case (order)
      2'd0: case (rank)
              0: m = M_CURSOR; 1: m = M_MAC;  2: m = M_USB;
              3: m = M_DMA;    4: m = M_CORE; default: m = M_RASTER;
            endcase
      2'd1: case (rank)
              0: m = M_RASTER; 1: m = M_CURSOR; 2: m = M_MAC;
              3: m = M_USB;    4: m = M_CORE;   default: m = M_DMA;
            endcase
      2'd2: case (rank)
              0: m = M_RASTER; 1: m = M_CURSOR; 2: m = M_DMA;
              3: m = M_USB;    4: m = M_MAC;    default: m = M_CORE;
            endcase
      default: case (rank)
              0: m = M_RASTER; 1: m = M_DMA;    2: m = M_MAC;
              3: m = M_USB;    4: m = M_CURSOR; default: m = M_CORE;
            endcase
    endcase
    return m;
  endfunction
endpackage

// File: rtl/arb_ctrl_reg.sv
module arb_ctrl_reg
  import arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output ctrl_t            ctrl_o,
  output logic [REG_W-1:0] rdata_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      ctrl_q.order   <= wdata_i[1:0];
      ctrl_q.boost   <= wdata_i[3];
      ctrl_q.dma_irq <= wdata_i[4];
      ctrl_q.dma_fiq <= wdata_i[5];
      ctrl_q.usb_irq <= wdata_i[6];
      ctrl_q.usb_fiq <= wdata_i[7];
      ctrl_q.mac_irq <= wdata_i[8];
      ctrl_q.mac_fiq <= wdata_i[9];
    end
  end

  always_comb begin
    rdata_o      = '0;
    rdata_o[1:0] = ctrl_q.order;
    rdata_o[3]   = ctrl_q.boost;
    rdata_o[4]   = ctrl_q.dma_irq;
    rdata_o[5]   = ctrl_q.dma_fiq;
    rdata_o[6]   = ctrl_q.usb_irq;
    rdata_o[7]   = ctrl_q.usb_fiq;
    rdata_o[8]   = ctrl_q.mac_irq;
    rdata_o[9]   = ctrl_q.mac_fiq;
  end

  assign ctrl_o = ctrl_q;

  // R2: reserved positions never read back as one
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rdata_o[REG_W-1:CTRL_W] == '0) && (rdata_o[2] == 1'b0));
endmodule

// File: rtl/arb_irq_mask.sv
module arb_irq_mask
  import arb_pkg::*;
(
  input  ctrl_t            ctrl_i,
  input  logic             irq_i,
  input  logic             fiq_i,
  output logic [NUM_M-1:0] blk_o
);
  logic [NUM_M-1:0] en_irq;
  logic [NUM_M-1:0] en_fiq;

  always_comb begin
    en_irq = '0;
    en_fiq = '0;
    en_irq[M_DMA] = ctrl_i.dma_irq;
    en_fiq[M_DMA] = ctrl_i.dma_fiq;
    en_irq[M_USB] = ctrl_i.usb_irq;
    en_fiq[M_USB] = ctrl_i.usb_fiq;
    en_irq[M_MAC] = ctrl_i.mac_irq;
    en_fiq[M_MAC] = ctrl_i.mac_fiq;
  end

  for (genvar i = 0; i < NUM_M; i++) begin : g_blk
    assign blk_o[i] = (en_irq[i] & irq_i) | (en_fiq[i] & fiq_i);
  end
endmodule

// File: rtl/arb_core.sv
module arb_core
  import arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NUM_M-1:0] req_i,
  input  logic [NUM_M-1:0] blk_i,
  input  logic [1:0]       order_i,
  input  logic             boost_en_i,
  output logic [NUM_M-1:0] gnt_o
);
  logic [NUM_M-1:0] gnt_q, gnt_d, elig, pick;
  logic             boost_q, boost_d, owner_ok;

  assign elig     = req_i & ~blk_i;
  assign owner_ok = |(gnt_q & elig);

  always_comb begin
    master_e m;
    pick = '0;
    for (int r = NUM_M - 1; r >= 0; r--) begin
      m = rank_master(order_i, r);
      if (elig[m]) begin
        pick    = '0;
        pick[m] = 1'b1;
      end
    end
    if (boost_en_i && boost_q && elig[M_CORE]) begin
      pick         = '0;
      pick[M_CORE] = 1'b1;
    end
    gnt_d = owner_ok ? gnt_q : pick;
  end

  always_comb begin
    if (gnt_d[M_CORE])  boost_d = 1'b0;
    else if (|gnt_d)    boost_d = 1'b1;
    else                boost_d = boost_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q   <= '0;
      boost_q <= 1'b0;
    end else begin
      gnt_q   <= gnt_d;
      boost_q <= boost_d;
    end
  end

  assign gnt_o = gnt_q;

  // R3: at most one owner
  assert_onehot_grant_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_q));
  // R3: grant only to a master that was requesting
  assert_grant_to_requester_R3: assert property (@(posedge clk) disable iff (rst)
    (gnt_q != '0) |-> ((gnt_q & $past(req_i)) == gnt_q));
  // R4: an eligible owner keeps the bus
  assert_hold_owner_R4: assert property (@(posedge clk) disable iff (rst)
    ((gnt_q != '0) && ((gnt_q & req_i & ~blk_i) == gnt_q)) |=> $stable(gnt_q));
  // R10: a blocked master is not granted at the next edge
  assert_blocked_no_grant_R10: assert property (@(posedge clk) disable iff (rst)
    (blk_i != '0) |=> ((gnt_q & $past(blk_i)) == '0));
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
  import arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NUM_M-1:0] req_i,
  input  logic             irq_i,
  input  logic             fiq_i,
  input  logic             cfg_wr_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  output logic [NUM_M-1:0] gnt_o
);
  ctrl_t            ctrl;
  logic [NUM_M-1:0] blk;

  arb_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en_i (cfg_wr_i),
    .wdata_i (cfg_wdata_i),
    .ctrl_o  (ctrl),
    .rdata_o (cfg_rdata_o)
  );

  arb_irq_mask u_mask (
    .ctrl_i (ctrl),
    .irq_i  (irq_i),
    .fiq_i  (fiq_i),
    .blk_o  (blk)
  );

  arb_core u_core (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .blk_i      (blk),
    .order_i    (ctrl.order),
    .boost_en_i (ctrl.boost),
    .gnt_o      (gnt_o)
  );
endmodule

// File: tb/test_prio_bus_arbiter.sv
module test_prio_bus_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  req = '0;
  logic        irq = 1'b0;
  logic        fiq = 1'b0;
  logic        wr  = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  gnt;

  int checks = 0;
  int fails  = 0;
  logic [5:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  prio_bus_arbiter i_prio_bus_arbiter (
    .clk(clk), .rst(rst), .req_i(req), .irq_i(irq), .fiq_i(fiq),
    .cfg_wr_i(wr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .gnt_o(gnt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected grant pushed to the scoreboard
  task automatic cyc(input logic [5:0] r, input logic i, input logic f,
                     input logic [5:0] exp, input string tag);
    @(negedge clk);
    req = r; irq = i; fiq = f;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic write_cfg(input logic [31:0] d);
    @(negedge clk);
    req = '0; irq = 1'b0; fiq = 1'b0;
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  // monitor: compares the grant after every edge with the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        logic [5:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {26'd0, gnt}, {26'd0, e});
      end
    end
  end

  initial begin
    #4_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 grant after reset", {26'd0, gnt}, 32'd0);
    check("R1 control after reset", rdata, 32'd0);

    write_cfg(32'hFFFF_FFFF);
    @(negedge clk);
    check("R2 reserved bits read zero", rdata, 32'h0000_03FB);
    write_cfg(32'h0000_0000);
    @(negedge clk);
    check("R2 cleared control", rdata, 32'd0);

    // table 0
    cyc(6'h3F, 0, 0, 6'h04, "R5 cursor first");
    cyc(6'h3F, 0, 0, 6'h04, "R4 owner held");
    cyc(6'h3B, 0, 0, 6'h08, "R5 mac next");
    cyc(6'h23, 0, 0, 6'h20, "R5 dma over core/raster");
    cyc(6'h03, 0, 0, 6'h01, "R5 core over raster");
    cyc(6'h03, 0, 0, 6'h01, "R4 core held");
    cyc(6'h02, 0, 0, 6'h02, "R5 raster last");
    cyc(6'h00, 0, 0, 6'h00, "R3 idle");

    // table 1
    write_cfg(32'h1);
    cyc(6'h3F, 0, 0, 6'h02, "R6 raster first");
    cyc(6'h39, 0, 0, 6'h08, "R6 mac over usb/core/dma");
    cyc(6'h21, 0, 0, 6'h01, "R6 core over dma");
    cyc(6'h00, 0, 0, 6'h00, "R3 idle");

    // table 2
    write_cfg(32'h2);
    cyc(6'h3F, 0, 0, 6'h02, "R7 raster first");
    cyc(6'h39, 0, 0, 6'h20, "R7 dma over usb/mac/core");
    cyc(6'h19, 0, 0, 6'h10, "R7 usb over mac");
    cyc(6'h09, 0, 0, 6'h08, "R7 mac over core");
    cyc(6'h00, 0, 0, 6'h00, "R3 idle");

    // table 3
    write_cfg(32'h3);
    cyc(6'h3F, 0, 0, 6'h02, "R8 raster first");
    cyc(6'h3D, 0, 0, 6'h20, "R8 dma second");
    cyc(6'h1D, 0, 0, 6'h08, "R8 mac over usb");
    cyc(6'h15, 0, 0, 6'h10, "R8 usb over cursor");
    cyc(6'h05, 0, 0, 6'h04, "R8 cursor over core");
    cyc(6'h00, 0, 0, 6'h00, "R3 idle");

    // core boost with table 0 (last grant was cursor)
    write_cfg(32'h8);
    cyc(6'h3F, 0, 0, 6'h01, "R9 boosted core wins");
    cyc(6'h3E, 0, 0, 6'h04, "R9 core dropped, cursor");
    cyc(6'h3B, 0, 0, 6'h01, "R9 boost restored");
    cyc(6'h3A, 0, 0, 6'h08, "R9 mac after core");
    cyc(6'h09, 0, 0, 6'h08, "R4 mac held over boosted core");
    cyc(6'h01, 0, 0, 6'h01, "R9 core granted");
    cyc(6'h00, 0, 0, 6'h00, "R3 idle");
    cyc(6'h21, 0, 0, 6'h20, "R9 boost gone after core grant");
    cyc(6'h01, 0, 0, 6'h01, "R9 core after dma");
    cyc(6'h00, 0, 0, 6'h00, "R3 idle");

    // DMA on IRQ
    write_cfg(32'h10);
    cyc(6'h20, 0, 0, 6'h20, "R10 dma granted");
    cyc(6'h21, 1, 0, 6'h01, "R12 revoke and hand to core");
    cyc(6'h20, 1, 0, 6'h00, "R10 dma ignored under irq");
    cyc(6'h20, 0, 0, 6'h20, "R10 dma served after irq clears");
    cyc(6'h20, 0, 1, 6'h20, "R11 fiq without enable no effect");
    cyc(6'h00, 0, 0, 6'h00, "R3 idle");

    // USB on FIQ
    write_cfg(32'h80);
    cyc(6'h10, 0, 0, 6'h10, "R11 usb granted");
    cyc(6'h10, 0, 1, 6'h00, "R11 usb revoked by fiq");
    cyc(6'h10, 1, 0, 6'h10, "R11 irq without usb enable no effect");
    cyc(6'h00, 0, 0, 6'h00, "R3 idle");

    // MAC on IRQ, USB unaffected
    write_cfg(32'h100);
    cyc(6'h08, 0, 0, 6'h08, "R11 mac granted");
    cyc(6'h18, 1, 0, 6'h10, "R12 mac revoked, usb same edge");
    cyc(6'h18, 1, 0, 6'h10, "R11 usb unaffected by mac enable");
    cyc(6'h00, 0, 0, 6'h00, "R3 idle");

    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule